// File: doc/BRIEF.md
# Displaced Set Index Hash for a Power-of-Two Cache

This block turns a physical line address into the set index of a large second-level cache. It does not take the index field of the address straight through. It first adds a fixed multiple of the tag to that field. The sum is then cut down to the width of the set index. Because the set count is a power of two, the cut is a plain truncation. Because the multiplier is odd, a constant stride in the tag moves the set by a constant, non-zero step. This spreads strided traffic over the sets without the irregular ordering that XOR-style hashes produce.

The multiplier is a parameter, with a default of 9. Only the low index-width bits of the product can reach the result. The product is therefore built from a few shifted copies of the truncated tag, one for each set bit of the constant, summed at index width. The adder width depends only on the set count, not on the address width.

The hashed index and the unchanged tag, which the cache stores for comparison, are presented one clock after a qualified request. They are marked by a registered valid flag.

Top module: `pd_set_hash`

## Requirements
- R1: The address is split with the line offset in bits [5:0], the index field x in bits [16:6] and the tag T in bits [31:17]. The offset bits have no influence on any output.
- R2: The set index equals (x + P·T) mod 2048, where P is the multiplier constant. The default P is 9, and P must be odd.
- R3: The product P·T is formed from shifted copies of the tag, one for each set bit of P, truncated to 11 bits. It equals the low 11 bits of the true product for every tag.
- R4: The tag output equals address bits [31:17] of the accepted request, unmodified.
- R5: The index and tag of a request sampled with in_valid high at a rising edge appear at the outputs right after that edge, with a latency of one cycle.
- R6: out_valid is high in exactly the cycle that follows an edge where in_valid was high, and low otherwise.
- R7: While in_valid is low, out_index and out_tag hold their previous values, whatever in_addr carries.
- R8: A synchronous active-high reset clears out_valid, out_index and out_tag to zero. It takes priority over a request presented at the same edge.
- R9: When the tag steps by one with x fixed, successive indices step by P modulo 2048. When the line address steps by one inside a tag, successive indices step by one modulo 2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_addr in this cycle |
| in_addr | input | 32 | Byte address of the access |
| out_valid | output | 1 | Registered result is valid |
| out_index | output | 11 | Displaced set index |
| out_tag | output | 15 | Tag field passed through for storage |

## Verification
A reset and a qualified request can arrive at the same clock edge, and the reset must win. This collision is forced twice: once during the initial reset with a non-zero address driven, and once in the middle of a run of random requests. In both cases the bench expects out_valid, out_index and out_tag to be zero right after the edge. It then expects normal hashing to resume on the next request. Three instances with multipliers 9, 19 and 31 share the same stimulus. Idle cycles with changing addresses are mixed in to test the hold behaviour.

// File: rtl/pdh_pkg.sv
`timescale 1ns/1ps
package pdh_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_OFF_W  = 6;
    localparam int DEF_SET_W  = 11;
    localparam int DEF_MULT   = 9;

    function automatic int tag_width(input int addr_w, input int off_w, input int set_w);
        return addr_w - off_w - set_w;
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic bit mult_bit(input int mult, input int pos);
        return ((mult >> pos) & 1) != 0;
    endfunction

endpackage

// File: rtl/pd_addr_split.sv
`timescale 1ns/1ps
module pd_addr_split #(
    parameter int ADDR_W = pdh_pkg::DEF_ADDR_W,
    parameter int OFF_W  = pdh_pkg::DEF_OFF_W,
    parameter int SET_W  = pdh_pkg::DEF_SET_W,
    localparam int TAG_W = pdh_pkg::tag_width(ADDR_W, OFF_W, SET_W)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  idx_field,
    output logic [TAG_W-1:0]  tag_field
);
    logic unused_offset;

    // R1: line offset is dropped, index and tag fields are sliced out
    assign unused_offset = ^addr[OFF_W-1:0];
    assign idx_field     = addr[OFF_W +: SET_W];
    assign tag_field     = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/pd_mult_trunc.sv
`timescale 1ns/1ps
module pd_mult_trunc #(
    parameter int TAG_W = 15,
    parameter int SET_W = pdh_pkg::DEF_SET_W,
    parameter int MULT  = pdh_pkg::DEF_MULT,
    localparam int USE_W = pdh_pkg::min_int(TAG_W, SET_W)
) (
    input  logic [TAG_W-1:0] tag,
    output logic [SET_W-1:0] prod
);
    logic [SET_W-1:0] tag_low;
    logic [SET_W-1:0] terms [SET_W];

    assign tag_low = SET_W'(tag[USE_W-1:0]);

    // One shifted copy of the tag per set bit of the constant (R3)
    for (genvar i = 0; i < SET_W; i++) begin : g_term
        if (pdh_pkg::mult_bit(MULT, i)) begin : g_on
            assign terms[i] = tag_low << i;
        end else begin : g_off
            assign terms[i] = '0;
        end
    end

    always_comb begin
        prod = '0;
        for (int k = 0; k < SET_W; k++) begin
            prod = prod + terms[k];
        end
    end

    // R3: the shift-add network agrees with a true multiply, truncated
    always_comb begin
        assert_shift_add_R3: assert (prod == SET_W'(tag * MULT))
            else $error("shift-add product mismatch");
    end

endmodule

// File: rtl/pd_out_stage.sv
`timescale 1ns/1ps
module pd_out_stage #(
    parameter int SET_W = pdh_pkg::DEF_SET_W,
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SET_W-1:0] idx_next,
    input  logic [TAG_W-1:0] tag_next,
    output logic             out_valid,
    output logic [SET_W-1:0] out_index,
    output logic [TAG_W-1:0] out_tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_index <= '0;
            out_tag   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_index <= idx_next;
                out_tag   <= tag_next;
            end
        end
    end

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_low_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_index) && $stable(out_tag)));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_index == $past(idx_next) && out_tag == $past(tag_next)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_index == '0 && out_tag == '0));

endmodule

// File: rtl/pd_set_hash.sv
`timescale 1ns/1ps
module pd_set_hash #(
    parameter int ADDR_W = pdh_pkg::DEF_ADDR_W,
    parameter int OFF_W  = pdh_pkg::DEF_OFF_W,
    parameter int SET_W  = pdh_pkg::DEF_SET_W,
    parameter int MULT   = pdh_pkg::DEF_MULT,
    localparam int TAG_W = pdh_pkg::tag_width(ADDR_W, OFF_W, SET_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [SET_W-1:0]  out_index,
    output logic [TAG_W-1:0]  out_tag
);
    logic [SET_W-1:0] idx_field;
    logic [TAG_W-1:0] tag_field;
    logic [SET_W-1:0] disp;
    logic [SET_W-1:0] idx_hashed;

    pd_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_split (
        .addr      (in_addr),
        .idx_field (idx_field),
        .tag_field (tag_field)
    );

    pd_mult_trunc #(.TAG_W(TAG_W), .SET_W(SET_W), .MULT(MULT)) u_mult (
        .tag  (tag_field),
        .prod (disp)
    );

    // R2: narrow add, carry out of the top bit discarded (power-of-two modulo)
    assign idx_hashed = idx_field + disp;

    pd_out_stage #(.SET_W(SET_W), .TAG_W(TAG_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .idx_next  (idx_hashed),
        .tag_next  (tag_field),
        .out_valid (out_valid),
        .out_index (out_index),
        .out_tag   (out_tag)
    );

    // R4: stored tag is the accepted address's upper field
    assert_tag_pass_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_tag == $past(in_addr[ADDR_W-1 -: TAG_W]));

endmodule

// File: tb/sim_pd_set_hash.sv
`timescale 1ns/1ps
module sim_pd_set_hash;

    localparam int P0 = 9;
    localparam int P1 = 19;
    localparam int P2 = 31;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_addr;
    logic        v0, v1, v2;
    logic [10:0] i0, i1, i2;
    logic [14:0] t0, t1, t2;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_addr;

    always #2.5 clk = ~clk;

    pd_set_hash u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
                    .out_valid(v0), .out_index(i0), .out_tag(t0));
    pd_set_hash #(.MULT(P1)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
                    .out_valid(v1), .out_index(i1), .out_tag(t1));
    pd_set_hash #(.MULT(P2)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
                    .out_valid(v2), .out_index(i2), .out_tag(t2));

    function automatic int exp_idx(input logic [31:0] a, input int p);
        int x = int'(a[16:6]);
        int t = int'(a[31:17]);
        return (x + p * t) & 2047;
    endfunction

    function automatic int exp_tag(input logic [31:0] a);
        return int'(a[31:17]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input logic [31:0] a, input string req);
        chk(v0 && v1 && v2, "R6 valid", int'(v0), 1);
        chk(int'(i0) == exp_idx(a, P0), req, int'(i0), exp_idx(a, P0));
        chk(int'(i1) == exp_idx(a, P1), req, int'(i1), exp_idx(a, P1));
        chk(int'(i2) == exp_idx(a, P2), req, int'(i2), exp_idx(a, P2));
        chk(int'(t0) == exp_tag(a) && t1 == t0 && t2 == t0, "R4 tag", int'(t0), exp_tag(a));
    endtask

    // R5: drive at negedge, sample 1 ns after the capturing edge
    task automatic apply(input logic [31:0] a, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        @(posedge clk);
        #1;
        last_addr = a;
        check_out(a, req);
    endtask

    task automatic idle(input logic [31:0] junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_addr  = junk;
        @(posedge clk);
        #1;
        chk(!v0 && !v1 && !v2, "R6 idle valid", int'(v0), 0);
        chk(int'(i0) == exp_idx(last_addr, P0), "R7 hold index", int'(i0), exp_idx(last_addr, P0));
        chk(int'(i2) == exp_idx(last_addr, P2), "R7 hold index", int'(i2), exp_idx(last_addr, P2));
        chk(int'(t0) == exp_tag(last_addr), "R7 hold tag", int'(t0), exp_tag(last_addr));
    endtask

    task automatic reset_collide(input logic [31:0] a);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_addr  = a;
        @(posedge clk);
        #1;
        chk(!v0 && !v1 && !v2, "R8 reset valid", int'(v0), 0);
        chk(i0 == '0 && i1 == '0 && i2 == '0, "R8 reset index", int'(i0), 0);
        chk(t0 == '0, "R8 reset tag", int'(t0), 0);
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        last_addr = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] base;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in_valid = 1'b1;
        in_addr = 32'hFFFF_FFC0;
        @(posedge clk);
        #1;
        chk(!v0 && !v1 && !v2, "R8 initial valid", int'(v0), 0);
        chk(i0 == '0 && i1 == '0 && i2 == '0, "R8 initial index", int'(i0), 0);
        chk(t0 == '0, "R8 initial tag", int'(t0), 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        last_addr = '0;

        // R2 corners
        apply(32'h0000_0000, "R2 zero");
        apply(32'h0002_0000, "R2 tag one");
        apply(32'hFFFF_FFFF, "R2 all ones");
        apply(32'h0001_FFC0, "R2 max x zero tag");

        // R1: offset bits must not matter
        base = 32'h8A5C_3240;
        apply(base, "R1 offset zero");
        apply(base | 32'h3F, "R1 offset ones");
        idle(base | 32'h15);

        // R9: tag stride, fixed x
        for (int k = 0; k < 24; k++) begin
            apply((32'(k) << 17) | (32'd5 << 6), "R9 tag stride");
            chk(int'(i0) == ((5 + P0 * k) & 2047), "R9 step by P", int'(i0), (5 + P0 * k) & 2047);
        end
        // R9: unit line stride inside one tag
        for (int k = 0; k < 16; k++) begin
            apply(32'h1234_1FC0 + 32'(k) * 32'd64, "R9 line stride");
        end

        // R7: idle with changing address
        idle(32'hDEAD_BEEF);
        idle(32'h0BAD_F00D);

        // random mix with R8 collision in the middle
        for (int n = 0; n < 400; n++) begin
            r = $urandom;
            if (n == 200) begin
                reset_collide(r);
            end else if (($urandom % 5) == 0) begin
                idle(r);
            end else begin
                apply(r, "R2 random");
            end
        end
        apply(32'h0004_0040, "R5 after collision");

        done = 1;
        finish_run();
    end

endmodule